// File: doc/BRIEF.md
# Number-indexed vectored interrupt controller

This block gathers 64 interrupt request lines and steers each one to one of two outputs. One is a normal interrupt output, ranked by a per-source priority and gated by a threshold. The other is a fast interrupt output with no ranking. Software programs it over a simple 32-bit register port with write strobe, read strobe, byte address and data buses. A single source can be switched on or off by writing its number to a set register or a clear register, which needs no read-modify-write. The full enable state can also be written as two words.

Each source has a route bit that sends it to the fast or the normal path, and a force bit that raises it without the input line. The block publishes the raw inputs and the pending set of each path as word pairs. It also offers two vector words. These name the winning normal source and the highest-numbered fast source, so a handler can dispatch after a single read. All outputs are registered. Reads return data on the cycle after the read strobe.

Top module: `numvec_intc`

## Requirements
- R1: After a synchronous reset, enables, routes, forces, priorities and the threshold are zero and both interrupt outputs are low. Reads of enable words return 0, and reads of both vector words return 0xFFFF0000.
- R2: A write to 0x08 sets the enable bit of the source numbered by wdata[5:0] and changes no other enable bit. A write to 0x0C clears only that bit. Reads of 0x08 and 0x0C return 0.
- R3: Enable state is read and written as two words: 0x14 holds sources 0-31 (bit n = source n) and 0x10 holds sources 32-63 (bit n = source 32+n).
- R4: Route words 0x1C (sources 0-31) and 0x18 (sources 32-63) hold one bit per source: 1 selects the fast path, 0 the normal path. Force words 0x54 (low) and 0x50 (high) are read/write with the same bit layout.
- R5: Raw words 0x4C (low) and 0x48 (high) return the source inputs as captured on the previous clock edge.
- R6: Normal pending words 0x5C/0x58 show (input OR force) AND enable AND NOT route. Fast pending words 0x64/0x60 show the same term with the route bit set. Low word first in each pair, same bit layout as R3.
- R7: Eight priority words hold a 4-bit priority per source. Word x sits at byte address 0x20 + 4*(7-x), and bits [4n+3:4n] of word x are the priority of source 8x+n. All eight are read/write.
- R8: The threshold at 0x04 is a signed 5-bit field in wdata[4:0] and reads back sign-extended to 32 bits. irq_norm is high when some normal pending source has a priority strictly greater than the threshold. Writing all ones (-1) therefore admits every priority.
- R9: Vector word 0x40 carries in bits [31:16] the number of the qualifying normal pending source with the highest priority. Among equal priorities the higher source number wins. The field is 0xFFFF when none qualifies, and bits [15:0] are zero.
- R10: irq_fast is the OR of all fast pending bits. Vector word 0x44 carries in bits [31:16] the highest-numbered fast pending source, or 0xFFFF when there is none, with bits [15:0] zero.
- R11: irq_norm, irq_fast and both vector words change on the first clock edge after a register write takes effect. After a source input change they change on the second edge, since the input is captured first. A read strobe loads rdata on that edge and rdata holds until the next strobe. Unmapped addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 64 | Interrupt request lines, bit n = source n |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 7 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| irq_norm | output | 1 | Normal interrupt request |
| irq_fast | output | 1 | Fast interrupt request |

## Verification
The bench builds the block with its default parameters: 64 sources, 4-bit priorities and a 32-bit data word. This size fills both halves of every word pair and all eight priority words, so the split between sources 31 and 32 is crossed, and so is the reversed order of the priority words. Directed cases cover the threshold at -1, at a value that equals a pending priority and at one just below it. They also cover priority ties broken by source number and sources raised by force alone. A random phase then mixes writes, reads, unaligned addresses and input changes against the behavioural model.

// File: rtl/intc_pkg.sv
package intc_pkg;

  // Byte addresses of the register map
  localparam int unsigned A_THRESH   = 32'h04;
  localparam int unsigned A_SETNUM   = 32'h08;
  localparam int unsigned A_CLRNUM   = 32'h0C;
  localparam int unsigned A_ENA_HI   = 32'h10;
  localparam int unsigned A_ENA_LO   = 32'h14;
  localparam int unsigned A_ROUTE_HI = 32'h18;
  localparam int unsigned A_ROUTE_LO = 32'h1C;
  localparam int unsigned A_PRIO_LO  = 32'h20;
  localparam int unsigned A_PRIO_HI  = 32'h3C;
  localparam int unsigned A_NVEC     = 32'h40;
  localparam int unsigned A_FVEC     = 32'h44;
  localparam int unsigned A_RAW_HI   = 32'h48;
  localparam int unsigned A_RAW_LO   = 32'h4C;
  localparam int unsigned A_FRC_HI   = 32'h50;
  localparam int unsigned A_FRC_LO   = 32'h54;
  localparam int unsigned A_NPND_HI  = 32'h58;
  localparam int unsigned A_NPND_LO  = 32'h5C;
  localparam int unsigned A_FPND_HI  = 32'h60;
  localparam int unsigned A_FPND_LO  = 32'h64;

  localparam logic [15:0] VEC_NONE = 16'hFFFF;

  typedef enum logic {PICK_BY_PRIO = 1'b0, PICK_BY_NUMBER = 1'b1} pick_mode_e;

endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 4,
  parameter int ADDR_W  = 7,
  parameter int DW      = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DW-1:0]             wdata,
  output logic [NUM_SRC-1:0]        en_q,
  output logic [NUM_SRC-1:0]        route_q,
  output logic [NUM_SRC-1:0]        force_q,
  output logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  output logic signed [PRIO_W:0]    thresh_q
);

  localparam int SRC_W = $clog2(NUM_SRC);
  localparam int PER_W = DW / PRIO_W;        // priorities per word
  localparam int NPW   = NUM_SRC / PER_W;    // number of priority words

  logic [SRC_W-1:0] num_sel;
  assign num_sel = wdata[SRC_W-1:0];

  // Enable bits: word writes and single-bit set/clear by number
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else if (wr_en) begin
      case (addr)
        ADDR_W'(A_SETNUM): en_q[num_sel] <= 1'b1;
        ADDR_W'(A_CLRNUM): en_q[num_sel] <= 1'b0;
        ADDR_W'(A_ENA_HI): en_q[NUM_SRC-1:DW] <= wdata;
        ADDR_W'(A_ENA_LO): en_q[DW-1:0] <= wdata;
        default: ;
      endcase
    end
  end

  // Route, force and threshold registers
  always_ff @(posedge clk) begin
    if (rst) begin
      route_q  <= '0;
      force_q  <= '0;
      thresh_q <= '0;
    end else if (wr_en) begin
      case (addr)
        ADDR_W'(A_ROUTE_HI): route_q[NUM_SRC-1:DW] <= wdata;
        ADDR_W'(A_ROUTE_LO): route_q[DW-1:0] <= wdata;
        ADDR_W'(A_FRC_HI):   force_q[NUM_SRC-1:DW] <= wdata;
        ADDR_W'(A_FRC_LO):   force_q[DW-1:0] <= wdata;
        ADDR_W'(A_THRESH):   thresh_q <= $signed(wdata[PRIO_W:0]);
        default: ;
      endcase
    end
  end

  // One priority field per source; word x is mapped in reverse order
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_prio
    localparam int WORD  = s / PER_W;
    localparam int SLOT  = s % PER_W;
    localparam int PADDR = A_PRIO_LO + 4 * (NPW - 1 - WORD);
    logic [PRIO_W-1:0] prio_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        prio_r <= '0;
      end else if (wr_en && addr == ADDR_W'(PADDR)) begin
        prio_r <= wdata[SLOT*PRIO_W +: PRIO_W];
      end
    end
    assign prio_flat[s*PRIO_W +: PRIO_W] = prio_r;
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (en_q == '0 && route_q == '0 && force_q == '0 && thresh_q == '0));

  // R2
  setnum_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(A_SETNUM)) |=>
      (en_q[$past(num_sel)] && $countones(en_q ^ $past(en_q)) <= 1));

  // R2
  clrnum_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(A_CLRNUM)) |=>
      (!en_q[$past(num_sel)] && $countones(en_q ^ $past(en_q)) <= 1));

  // R3
  ena_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(A_ENA_LO)) |=>
      (en_q[DW-1:0] == $past(wdata) && $stable(en_q[NUM_SRC-1:DW])));

endmodule

// File: rtl/intc_pick.sv
module intc_pick
  import intc_pkg::*;
#(
  parameter int         NUM_SRC = 64,
  parameter int         PRIO_W  = 4,
  parameter pick_mode_e MODE    = PICK_BY_PRIO,
  localparam int        SRC_W   = $clog2(NUM_SRC)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SRC-1:0]        pend,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  input  logic signed [PRIO_W:0]    thresh,
  output logic                      valid,
  output logic [SRC_W-1:0]          idx
);

  if (MODE == PICK_BY_PRIO) begin : g_prio
    logic [PRIO_W-1:0] best;
    logic [PRIO_W-1:0] cur;

    // Ascending scan with >= hands ties to the higher source number
    always_comb begin
      valid = 1'b0;
      idx   = '0;
      best  = '0;
      cur   = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
        cur = prio_flat[i*PRIO_W +: PRIO_W];
        if (pend[i] && ($signed({1'b0, cur}) > thresh) && (!valid || cur >= best)) begin
          valid = 1'b1;
          idx   = SRC_W'(i);
          best  = cur;
        end
      end
    end

    // R9
    prio_win_chk: assert property (@(posedge clk) disable iff (rst)
      valid |-> (pend[idx] &&
                 $signed({1'b0, prio_flat[idx*PRIO_W +: PRIO_W]}) > thresh));
  end else begin : g_num
    always_comb begin
      valid = 1'b0;
      idx   = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
        if (pend[i]) begin
          valid = 1'b1;
          idx   = SRC_W'(i);
        end
      end
    end

    // R10
    num_win_chk: assert property (@(posedge clk) disable iff (rst)
      valid |-> ((pend >> idx) == NUM_SRC'(1)));
  end

endmodule

// File: rtl/numvec_intc.sv
module numvec_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 4,
  parameter int ADDR_W  = 7,
  parameter int DW      = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rdata,
  output logic               irq_norm,
  output logic               irq_fast
);

  localparam int SRC_W = $clog2(NUM_SRC);
  localparam int PER_W = DW / PRIO_W;
  localparam int NPW   = NUM_SRC / PER_W;
  localparam int PW_W  = $clog2(NPW);
  localparam int HW    = DW / 2;

  logic [NUM_SRC-1:0]        en_q, route_q, force_q, src_q;
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic signed [PRIO_W:0]    thresh_q;
  logic [NUM_SRC-1:0]        pend_n, pend_f;
  logic                      n_valid, f_valid;
  logic [SRC_W-1:0]          n_idx, f_idx;
  logic [HW-1:0]             nvec_q, fvec_q;
  logic [DW-1:0]             rd_mux;
  logic [PW_W-1:0]           pword;

  intc_regs #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DW(DW)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .en_q     (en_q),
    .route_q  (route_q),
    .force_q  (force_q),
    .prio_flat(prio_flat),
    .thresh_q (thresh_q)
  );

  // Source capture
  always_ff @(posedge clk) begin
    if (rst) src_q <= '0;
    else     src_q <= src_in;
  end

  assign pend_n = (src_q | force_q) & en_q & ~route_q;
  assign pend_f = (src_q | force_q) & en_q & route_q;

  intc_pick #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .MODE(PICK_BY_PRIO)
  ) u_pick_norm (
    .clk      (clk),
    .rst      (rst),
    .pend     (pend_n),
    .prio_flat(prio_flat),
    .thresh   (thresh_q),
    .valid    (n_valid),
    .idx      (n_idx)
  );

  intc_pick #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .MODE(PICK_BY_NUMBER)
  ) u_pick_fast (
    .clk      (clk),
    .rst      (rst),
    .pend     (pend_f),
    .prio_flat(prio_flat),
    .thresh   (thresh_q),
    .valid    (f_valid),
    .idx      (f_idx)
  );

  // Registered outputs and vector words
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_norm <= 1'b0;
      irq_fast <= 1'b0;
      nvec_q   <= VEC_NONE;
      fvec_q   <= VEC_NONE;
    end else begin
      irq_norm <= n_valid;
      irq_fast <= |pend_f;
      nvec_q   <= n_valid ? HW'(n_idx) : VEC_NONE;
      fvec_q   <= f_valid ? HW'(f_idx) : VEC_NONE;
    end
  end

  // Priority word x lives at base + 4*(NPW-1-x)
  assign pword = PW_W'(NPW - 1) - addr[PW_W+1:2];

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADDR_W'(A_THRESH):   rd_mux = DW'(thresh_q);
      ADDR_W'(A_ENA_HI):   rd_mux = en_q[NUM_SRC-1:DW];
      ADDR_W'(A_ENA_LO):   rd_mux = en_q[DW-1:0];
      ADDR_W'(A_ROUTE_HI): rd_mux = route_q[NUM_SRC-1:DW];
      ADDR_W'(A_ROUTE_LO): rd_mux = route_q[DW-1:0];
      ADDR_W'(A_NVEC):     rd_mux = {nvec_q, {HW{1'b0}}};
      ADDR_W'(A_FVEC):     rd_mux = {fvec_q, {HW{1'b0}}};
      ADDR_W'(A_RAW_HI):   rd_mux = src_q[NUM_SRC-1:DW];
      ADDR_W'(A_RAW_LO):   rd_mux = src_q[DW-1:0];
      ADDR_W'(A_FRC_HI):   rd_mux = force_q[NUM_SRC-1:DW];
      ADDR_W'(A_FRC_LO):   rd_mux = force_q[DW-1:0];
      ADDR_W'(A_NPND_HI):  rd_mux = pend_n[NUM_SRC-1:DW];
      ADDR_W'(A_NPND_LO):  rd_mux = pend_n[DW-1:0];
      ADDR_W'(A_FPND_HI):  rd_mux = pend_f[NUM_SRC-1:DW];
      ADDR_W'(A_FPND_LO):  rd_mux = pend_f[DW-1:0];
      default: begin
        if (addr >= ADDR_W'(A_PRIO_LO) && addr <= ADDR_W'(A_PRIO_HI) && addr[1:0] == 2'b00)
          rd_mux = prio_flat[pword*DW +: DW];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R8
  norm_vec_chk: assert property (@(posedge clk) disable iff (rst)
    irq_norm |-> (nvec_q != VEC_NONE));

  // R10
  fast_vec_chk: assert property (@(posedge clk) disable iff (rst)
    irq_fast == (fvec_q != VEC_NONE));

endmodule

// File: tb/tb_numvec_intc.sv
module tb_numvec_intc;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src_in = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_norm, irq_fast;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit started = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  numvec_intc dut (
    .clk(clk), .rst(rst), .src_in(src_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_norm(irq_norm), .irq_fast(irq_fast)
  );

  // ---------------- behavioural reference model ----------------
  bit m_en[64], m_ty[64], m_fr[64], m_sq[64];
  int m_pr[64];
  int m_mask;
  bit m_irqn, m_irqf;
  int m_nvec = 16'hFFFF, m_fvec = 16'hFFFF;
  logic [31:0] m_rd = '0;

  function bit npend(int i);
    return (m_sq[i] | m_fr[i]) & m_en[i] & !m_ty[i];
  endfunction
  function bit fpend(int i);
    return (m_sq[i] | m_fr[i]) & m_en[i] & m_ty[i];
  endfunction

  function logic [31:0] mread(logic [6:0] a);
    logic [31:0] v;
    int base;
    v = '0;
    base = a[2] ? 0 : 32;  // odd word address: low half; even: high half
    if (a >= 7'h20 && a <= 7'h3C && a[1:0] == 2'b00) begin
      int x;
      x = 7 - (int'(a) - 32) / 4;
      for (int n = 0; n < 8; n++) v[4*n +: 4] = 4'(m_pr[8*x + n]);
      return v;
    end
    case (a)
      7'h04: v = 32'(m_mask);
      7'h40: v = {16'(m_nvec), 16'h0};
      7'h44: v = {16'(m_fvec), 16'h0};
      7'h10, 7'h14: for (int i = 0; i < 32; i++) v[i] = m_en[base + i];
      7'h18, 7'h1C: for (int i = 0; i < 32; i++) v[i] = m_ty[base + i];
      7'h48, 7'h4C: for (int i = 0; i < 32; i++) v[i] = m_sq[base + i];
      7'h50, 7'h54: for (int i = 0; i < 32; i++) v[i] = m_fr[base + i];
      7'h58, 7'h5C: for (int i = 0; i < 32; i++) v[i] = npend(base + i);
      7'h60, 7'h64: for (int i = 0; i < 32; i++) v[i] = fpend(base + i);
      default: v = '0;
    endcase
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) begin
        m_en[i] = 0; m_ty[i] = 0; m_fr[i] = 0; m_sq[i] = 0; m_pr[i] = 0;
      end
      m_mask = 0; m_irqn = 0; m_irqf = 0;
      m_nvec = 16'hFFFF; m_fvec = 16'hFFFF; m_rd = '0;
    end else begin
      int best, bp, fbest;
      int base;
      best = -1; bp = -1; fbest = -1;
      for (int i = 0; i < 64; i++) begin
        if (npend(i) && m_pr[i] > m_mask && m_pr[i] >= bp) begin
          best = i; bp = m_pr[i];
        end
        if (fpend(i)) fbest = i;
      end
      if (rd_en) m_rd = mread(addr);
      m_irqn = (best >= 0);
      m_nvec = (best >= 0) ? best : 16'hFFFF;
      m_irqf = (fbest >= 0);
      m_fvec = (fbest >= 0) ? fbest : 16'hFFFF;
      if (wr_en) begin
        base = addr[2] ? 0 : 32;
        if (addr >= 7'h20 && addr <= 7'h3C && addr[1:0] == 2'b00) begin
          int x;
          x = 7 - (int'(addr) - 32) / 4;
          for (int n = 0; n < 8; n++) m_pr[8*x + n] = int'(wdata[4*n +: 4]);
        end
        case (addr)
          7'h04: m_mask = wdata[4] ? int'(wdata[4:0]) - 32 : int'(wdata[4:0]);
          7'h08: m_en[wdata[5:0]] = 1;
          7'h0C: m_en[wdata[5:0]] = 0;
          7'h10, 7'h14: for (int i = 0; i < 32; i++) m_en[base + i] = wdata[i];
          7'h18, 7'h1C: for (int i = 0; i < 32; i++) m_ty[base + i] = wdata[i];
          7'h50, 7'h54: for (int i = 0; i < 32; i++) m_fr[base + i] = wdata[i];
          default: ;
        endcase
      end
      for (int i = 0; i < 64; i++) m_sq[i] = src_in[i];
    end
    started = 1'b1;
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Model comparison on every clock, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R8 irq_norm vs model", 32'(irq_norm), 32'(m_irqn));
      chk("R10 irq_fast vs model", 32'(irq_fast), 32'(m_irqf));
      chk("R11 rdata vs model", rdata, m_rd);
    end
  end

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    chk(tag, rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    chk("R1 irq_norm", 32'(irq_norm), 0);
    chk("R1 irq_fast", 32'(irq_fast), 0);
    rd(7'h14, 32'h0, "R1 enable low");
    rd(7'h10, 32'h0, "R1 enable high");
    rd(7'h40, 32'hFFFF0000, "R1 normal vector");
    rd(7'h44, 32'hFFFF0000, "R1 fast vector");

    // R3 enable words
    wr(7'h14, 32'hA5A50001);
    wr(7'h10, 32'h80000000);
    rd(7'h14, 32'hA5A50001, "R3 enable low");
    rd(7'h10, 32'h80000000, "R3 enable high");

    // R2 set/clear by number
    wr(7'h08, 32'd5);
    rd(7'h14, 32'hA5A50021, "R2 set 5");
    wr(7'h0C, 32'd0);
    rd(7'h14, 32'hA5A50020, "R2 clear 0");
    wr(7'h08, 32'd33);
    rd(7'h10, 32'h80000002, "R2 set 33");
    wr(7'h08, 32'h00000147);
    rd(7'h14, 32'hA5A500A0, "R2 only low bits select");
    rd(7'h08, 32'h0, "R2 set reg reads zero");
    rd(7'h0C, 32'h0, "R2 clear reg reads zero");

    // R4 route and force words
    wr(7'h1C, 32'h00001000);
    wr(7'h18, 32'h00040000);
    rd(7'h1C, 32'h00001000, "R4 route low");
    rd(7'h18, 32'h00040000, "R4 route high");
    wr(7'h54, 32'h00000003);
    rd(7'h54, 32'h00000003, "R4 force low");
    wr(7'h54, 32'h0);
    wr(7'h14, 32'h0);
    wr(7'h10, 32'h0);

    // R11 unmapped address ignores write, reads zero
    wr(7'h68, 32'hFFFFFFFF);
    rd(7'h68, 32'h0, "R11 unmapped read");

    // Enable 3, 12, 40, 50; 12 and 50 are routed fast
    wr(7'h08, 32'd3);
    wr(7'h08, 32'd12);
    wr(7'h08, 32'd40);
    wr(7'h08, 32'd50);
    @(negedge clk);
    src_in = (64'd1 << 3) | (64'd1 << 12) | (64'd1 << 40) | (64'd1 << 50) | (64'd1 << 7);
    idle(2);
    rd(7'h4C, 32'h00001088, "R5 raw low");
    rd(7'h48, 32'h00040100, "R5 raw high");
    rd(7'h5C, 32'h00000008, "R6 normal pending low");
    rd(7'h58, 32'h00000100, "R6 normal pending high");
    rd(7'h64, 32'h00001000, "R6 fast pending low");
    rd(7'h60, 32'h00040000, "R6 fast pending high");
    chk("R10 fast output high", 32'(irq_fast), 1);
    rd(7'h44, 32'h00320000, "R10 fast vector highest number");

    // R8 threshold 0 blocks priority 0
    chk("R8 blocked at threshold 0", 32'(irq_norm), 0);
    rd(7'h40, 32'hFFFF0000, "R9 none qualifies");
    wr(7'h04, 32'hFFFFFFFF);
    idle(2);
    chk("R8 all-ones admits all", 32'(irq_norm), 1);
    rd(7'h04, 32'hFFFFFFFF, "R8 threshold sign-extended");
    rd(7'h40, 32'h00280000, "R9 tie at 0 to higher number");

    // R7 priority words in reverse order
    wr(7'h3C, 32'h00009000);
    wr(7'h28, 32'h00000009);
    rd(7'h3C, 32'h00009000, "R7 word 0 at 0x3C");
    rd(7'h28, 32'h00000009, "R7 word 5 at 0x28");
    rd(7'h20, 32'h00000000, "R7 word 7 at 0x20");
    rd(7'h40, 32'h00280000, "R9 tie at 9 to higher number");
    wr(7'h3C, 32'h0000A000);
    idle(2);
    rd(7'h40, 32'h00030000, "R9 higher priority wins");
    wr(7'h04, 32'd9);
    idle(2);
    chk("R8 priority above threshold", 32'(irq_norm), 1);
    rd(7'h40, 32'h00030000, "R9 only source 3 above 9");
    wr(7'h04, 32'd10);
    idle(2);
    chk("R8 equal to threshold blocked", 32'(irq_norm), 0);
    rd(7'h40, 32'hFFFF0000, "R9 none above 10");

    // R10 disabling fast sources
    wr(7'h0C, 32'd50);
    idle(2);
    rd(7'h44, 32'h000C0000, "R10 next fast source");
    wr(7'h0C, 32'd12);
    idle(2);
    chk("R10 fast output low", 32'(irq_fast), 0);
    rd(7'h44, 32'hFFFF0000, "R10 no fast pending");

    // R6 force alone raises a source
    @(negedge clk);
    src_in = '0;
    wr(7'h04, 32'hFFFFFFFF);
    wr(7'h50, 32'h00000100);
    idle(2);
    rd(7'h58, 32'h00000100, "R6 forced pending");
    rd(7'h40, 32'h00280000, "R9 forced source vector");
    chk("R8 forced source raises output", 32'(irq_norm), 1);

    // Random phase, compared against the model every clock
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      wr_en = ($urandom % 3) == 0;
      rd_en = ($urandom % 2) == 0;
      wdata = $urandom;
      case ($urandom % 12)
        0: addr = 7'h04;
        1: addr = 7'h08;
        2: addr = 7'h0C;
        3: addr = 7'h10;
        4: addr = 7'h14;
        5: addr = 7'h18;
        6: addr = 7'h1C;
        7: addr = 7'h50;
        8: addr = 7'h54;
        9: addr = 7'(32'h20 + 4 * ($urandom % 8));
        10: addr = 7'(32'h40 + 4 * ($urandom % 10));
        default: addr = 7'($urandom);
      endcase
      if (addr == 7'h04 && ($urandom % 2) == 0) wdata = 32'hFFFFFFFF;
      if (($urandom % 4) == 0) src_in = {$urandom, $urandom} & {$urandom, $urandom};
    end
    @(negedge clk);
    wr_en = 1'b0;
    rd_en = 1'b0;
    idle(3);
    finish_run();
  end

endmodule